// File: doc/BRIEF.md
# Interrupt Control and Status Register

This block is a single 16-bit register that sits between a priority interrupt controller and a processor core. It conditions two external active-low request pins, A and B. Each pin passes through a synchronizer and can then be sensed either by its low level or by its falling edge. The block combines the qualified requests into one interrupt line to the core, and a global disable bit can block that line.

When the core accepts a vector, it pulses a take strobe carrying the vector number and the nested-priority requirement, and the register keeps both for software to read. While the chip is in a stop or wait low-power mode, both pins are sensed by level, whatever their edge-select bits say. The core reads the whole word at once and writes it with a one-cycle write strobe.

Top module: `irq_csr_unit`

## Requirements
- R1: After reset, with both pins held high, `rd_data` reads 16'h001C and `irq_out` is 0.
- R2: Bit 4 always reads 1, and writing 0 to it has no effect.
- R3: Bit 2 mirrors pin A and bit 3 mirrors pin B. Each follows its pin after two clock edges, which is the depth of the synchronizer.
- R4: In level mode (edge-select bit = 0), a pin held low raises `irq_out` two edges after the pin falls. `irq_out` drops two edges after the pin returns high, provided no other request is active.
- R5: In edge mode (edge-select bit = 1), a falling edge sets a pending flag three edges after the pin falls. The flag keeps `irq_out` high after the pin returns high. It clears only when a take carries that pin's vector number (`VEC_A` = 8 for A, `VEC_B` = 9 for B). A take with any other vector number leaves it set.
- R6: While `low_power` is 1, both pins are sensed by level even when their edge-select bit is 1. A pulse in this mode leaves no pending request behind.
- R7: Bit 5 is a read/write global disable with reset value 0. While it is 1, `irq_out` and bit 15 are 0. Pending requests survive and reappear when the bit returns to 0.
- R8: On a cycle with `vec_take` = 1, `vec_prio` is captured into bits 14:13 and `vec_num` into bits 12:6. On all other cycles these bits hold their value.
- R9: A second take overwrites the captured fields, whether or not software has read them.
- R10: Writes have no effect on the read-only bits 15:6, 4, 3 and 2.
- R11: Bit 15 equals `irq_out`.
- R12: Bit 1 (edge select for B) and bit 0 (edge select for A) are read/write, reset to 0, and take effect on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Register write data |
| rd_data | output | 16 | Register read data |
| pin_a_n | input | 1 | External request A, active low |
| pin_b_n | input | 1 | External request B, active low |
| low_power | input | 1 | Stop or wait mode indication |
| vec_take | input | 1 | Core accepts a vector this cycle |
| vec_num | input | 7 | Vector number of the accepted interrupt |
| vec_prio | input | 2 | Nested-priority requirement of the accepted interrupt |
| irq_out | output | 1 | Interrupt request to the core |

## Verification
The hardest situation to reach from the ports is a pending edge request that must survive conditions that would hide it. The bench latches a falling-edge request and then disables interrupts globally, and the request has to reappear when the disable bit is cleared. In a separate test it pulses a pin while the low-power indication is high, and no latent request may surface once the low-power mode ends. To show that clearing is tied to the correct source, a take with the wrong vector number is issued first and must leave the request standing; only a take with the matching number may clear it.

// File: rtl/irq_csr_pkg.sv
package irq_csr_pkg;
    localparam int REG_W  = 16;
    localparam int VEC_W  = 7;
    localparam int PRIO_W = 2;
    localparam int NPINS  = 2;

    // bit positions the core's software decodes
    localparam int B_IRQ  = 15;
    localparam int B_DIS  = 5;
    localparam int B_EDGB = 1;
    localparam int B_EDGA = 0;

    typedef struct packed {
        logic dis;
        logic edge_b;
        logic edge_a;
    } ctl_t;

    typedef struct packed {
        logic [PRIO_W-1:0] prio;
        logic [VEC_W-1:0]  vec;
    } cap_t;

    function automatic logic [REG_W-1:0] pack_status(
        input logic irq, input cap_t cap, input ctl_t ctl,
        input logic lvl_b, input logic lvl_a);
        return {irq, cap.prio, cap.vec, ctl.dis, 1'b1, lvl_b, lvl_a,
                ctl.edge_b, ctl.edge_a};
    endfunction
endpackage

// File: rtl/irq_pin_cond.sv
module irq_pin_cond
    import irq_csr_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter logic [VEC_W-1:0] MY_VEC = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pin_n,
    input  logic             edge_sel,
    input  logic             low_power,
    input  logic             take,
    input  logic [VEC_W-1:0] take_vec,
    output logic             level,
    output logic             req
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   pend_q;
    logic                   use_edge;
    logic                   fell;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '1;
            prev_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], pin_n};
            prev_q <= sync_q[SYNC_STAGES-1];
        end
    end

    assign level    = sync_q[SYNC_STAGES-1];
    assign use_edge = edge_sel & ~low_power;
    assign fell     = prev_q & ~level;

    always_ff @(posedge clk) begin
        if (rst)
            pend_q <= 1'b0;
        else if (use_edge && fell)
            pend_q <= 1'b1;
        else if (take && take_vec == MY_VEC)
            pend_q <= 1'b0;
    end

    assign req = use_edge ? pend_q : ~level;
endmodule

// File: rtl/irq_ctl_reg.sv
module irq_ctl_reg
    import irq_csr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output ctl_t             ctl
);
    always_ff @(posedge clk) begin
        if (rst)
            ctl <= '0;
        else if (wr_en) begin
            ctl.dis    <= wr_data[B_DIS];
            ctl.edge_b <= wr_data[B_EDGB];
            ctl.edge_a <= wr_data[B_EDGA];
        end
    end
endmodule

// File: rtl/irq_vec_capture.sv
module irq_vec_capture
    import irq_csr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic [VEC_W-1:0]  vec_num,
    input  logic [PRIO_W-1:0] vec_prio,
    output cap_t              cap
);
    always_ff @(posedge clk) begin
        if (rst)
            cap <= '0;
        else if (take) begin
            cap.prio <= vec_prio;
            cap.vec  <= vec_num;
        end
    end
endmodule

// File: rtl/irq_csr_unit.sv
module irq_csr_unit
    import irq_csr_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter logic [VEC_W-1:0] VEC_A = 7'd8,
    parameter logic [VEC_W-1:0] VEC_B = 7'd9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_data,
    output logic [REG_W-1:0]  rd_data,
    input  logic              pin_a_n,
    input  logic              pin_b_n,
    input  logic              low_power,
    input  logic              vec_take,
    input  logic [VEC_W-1:0]  vec_num,
    input  logic [PRIO_W-1:0] vec_prio,
    output logic              irq_out
);
    ctl_t             ctl;
    cap_t             cap;
    logic [NPINS-1:0] pins_n;
    logic [NPINS-1:0] edge_sel;
    logic [NPINS-1:0] lvl;
    logic [NPINS-1:0] req;

    assign pins_n   = {pin_b_n, pin_a_n};
    assign edge_sel = {ctl.edge_b, ctl.edge_a};

    irq_ctl_reg u_ctl (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .ctl(ctl)
    );

    irq_vec_capture u_cap (
        .clk(clk), .rst(rst), .take(vec_take), .vec_num(vec_num),
        .vec_prio(vec_prio), .cap(cap)
    );

    for (genvar g = 0; g < NPINS; g++) begin : g_pin
        localparam logic [VEC_W-1:0] PIN_VEC = (g == 0) ? VEC_A : VEC_B;
        irq_pin_cond #(.SYNC_STAGES(SYNC_STAGES), .MY_VEC(PIN_VEC)) u_pin (
            .clk(clk), .rst(rst), .pin_n(pins_n[g]), .edge_sel(edge_sel[g]),
            .low_power(low_power), .take(vec_take), .take_vec(vec_num),
            .level(lvl[g]), .req(req[g])
        );
    end

    assign irq_out = (|req) & ~ctl.dis;
    assign rd_data = pack_status(irq_out, cap, ctl, lvl[1], lvl[0]);
endmodule

// File: rtl/irq_csr_chk.sv
module irq_csr_chk
    import irq_csr_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [REG_W-1:0]  rd_data,
    input logic              low_power,
    input logic              vec_take,
    input logic [VEC_W-1:0]  vec_num,
    input logic [PRIO_W-1:0] vec_prio,
    input logic              irq_out
);
    // R2
    reserved_one_chk: assert property (@(posedge clk) disable iff (rst)
        rd_data[4] == 1'b1);

    // R7
    disable_blocks_chk: assert property (@(posedge clk) disable iff (rst)
        rd_data[5] |-> !irq_out);

    // R8
    capture_vec_chk: assert property (@(posedge clk) disable iff (rst)
        vec_take |=> rd_data[12:6] == $past(vec_num)
                     && rd_data[14:13] == $past(vec_prio));

    // R8
    capture_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !vec_take |=> $stable(rd_data[14:6]));

    // R12
    ctl_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable({rd_data[5], rd_data[1:0]}));

    // R6
    lowpower_level_chk: assert property (@(posedge clk) disable iff (rst)
        (low_power && !rd_data[5] && !rd_data[2]) |-> irq_out);
endmodule

bind irq_csr_unit irq_csr_chk i_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_data(rd_data),
    .low_power(low_power), .vec_take(vec_take), .vec_num(vec_num),
    .vec_prio(vec_prio), .irq_out(irq_out)
);

// File: tb/test_irq_csr_unit.sv
module test_irq_csr_unit;
    logic        clk = 0;
    logic        rst = 1;
    logic        wr_en = 0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        pin_a_n = 1, pin_b_n = 1, low_power = 0;
    logic        vec_take = 0;
    logic [6:0]  vec_num = '0;
    logic [1:0]  vec_prio = '0;
    logic        irq_out;
    int checks = 0, failures = 0;
    bit done = 0;

    always #5 clk = ~clk;

    irq_csr_unit i_irq_csr_unit (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .pin_a_n(pin_a_n), .pin_b_n(pin_b_n),
        .low_power(low_power), .vec_take(vec_take), .vec_num(vec_num),
        .vec_prio(vec_prio), .irq_out(irq_out)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [15:0] d);
        wr_en = 1; wr_data = d; tick(1); wr_en = 0;
    endtask

    task automatic take(input logic [6:0] v, input logic [1:0] p);
        vec_take = 1; vec_num = v; vec_prio = p; tick(1); vec_take = 0;
    endtask

    task automatic t_reset;
        chk("R1 reset read", rd_data, 16'h001C);
        chk("R1 reset irq", {15'd0, irq_out}, 16'd0);
    endtask

    task automatic t_readonly;
        wr(16'hFFDC);
        chk("R10 ro bits unchanged", rd_data, 16'h001C);
        wr(16'h0000);
        chk("R2 reserved stays 1", rd_data, 16'h001C);
        wr(16'h0003);
        chk("R12 edge bits written", rd_data, 16'h001F);
        wr(16'h0000);
        chk("R12 edge bits cleared", rd_data, 16'h001C);
    endtask

    task automatic t_level;
        pin_b_n = 0; tick(1);
        chk("R4 not yet", {15'd0, irq_out}, 16'd0);
        tick(1);
        chk("R4 level irq", {15'd0, irq_out}, 16'd1);
        chk("R3 pin B mirror low", {15'd0, rd_data[3]}, 16'd0);
        chk("R11 bit15 high", {15'd0, rd_data[15]}, 16'd1);
        pin_b_n = 1; tick(2);
        chk("R4 level release", {15'd0, irq_out}, 16'd0);
        chk("R3 pin B mirror high", {15'd0, rd_data[3]}, 16'd1);
        pin_a_n = 0; tick(2);
        chk("R3 pin A mirror low", {15'd0, rd_data[2]}, 16'd0);
        pin_a_n = 1; tick(2);
    endtask

    task automatic t_edge;
        wr(16'h0001);
        pin_a_n = 0; tick(2);
        chk("R5 edge not level", {15'd0, irq_out}, 16'd0);
        tick(1);
        chk("R5 edge pending", {15'd0, irq_out}, 16'd1);
        pin_a_n = 1; tick(3);
        chk("R5 pending held", {15'd0, irq_out}, 16'd1);
        take(7'd9, 2'd0);
        chk("R5 wrong vector keeps", {15'd0, irq_out}, 16'd1);
        take(7'd8, 2'd0);
        chk("R5 own vector clears", {15'd0, irq_out}, 16'd0);
        wr(16'h0000);
    endtask

    task automatic t_lowpower;
        wr(16'h0003);
        low_power = 1;
        pin_a_n = 0; tick(2);
        chk("R6 level in low power", {15'd0, irq_out}, 16'd1);
        pin_a_n = 1; tick(3);
        chk("R6 released", {15'd0, irq_out}, 16'd0);
        low_power = 0; tick(1);
        chk("R6 no latent pending", {15'd0, irq_out}, 16'd0);
        wr(16'h0000);
    endtask

    task automatic t_disable;
        wr(16'h0002);
        pin_b_n = 0; tick(3); pin_b_n = 1; tick(2);
        chk("R7 pending before disable", {15'd0, irq_out}, 16'd1);
        wr(16'h0022);
        chk("R7 disabled irq", {15'd0, irq_out}, 16'd0);
        chk("R7 disabled bit15 and bit5", rd_data & 16'h8020, 16'h0020);
        wr(16'h0002);
        chk("R7 pending returns", {15'd0, irq_out}, 16'd1);
        take(7'd9, 2'd1);
        chk("R5 B cleared by own vector", {15'd0, irq_out}, 16'd0);
        wr(16'h0000);
    endtask

    task automatic t_capture;
        take(7'h55, 2'd2);
        chk("R8 capture", rd_data, {1'b0, 2'd2, 7'h55, 6'b011100});
        tick(3);
        chk("R8 hold", rd_data, {1'b0, 2'd2, 7'h55, 6'b011100});
        take(7'h12, 2'd3);
        chk("R9 nested overwrite", rd_data, {1'b0, 2'd3, 7'h12, 6'b011100});
    endtask

    initial begin
        for (int i = 0; i < 100000 && !done; i++) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst = 0;
        tick(1);
        t_reset();
        t_readonly();
        t_level();
        t_edge();
        t_lowpower();
        t_disable();
        t_capture();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule